// File: doc/BRIEF.md
# Thermal Tug-of-War Game Controller

This block runs one round of a two-sensor biofeedback game. Two unsigned temperature readings arrive, each with its own valid strobe. While the game is idle, the block keeps a reference value for each sensor. That reference is the latest valid reading. Pulsing `start` moves the game into play and does four things at once:

- it freezes both references as the baselines;
- it latches the mode select;
- it centres the signed cursor at zero;
- it raises `ready`.

Each qualifying cycle during play moves the cursor by at most one step. The step depends on how far each sensor has drifted from its own baseline. Each drift is the current reading minus that sensor's baseline. The round ends when the cursor reaches either end of its range. At that point the matching win flag rises, `ready` falls, and everything stays frozen until reset.

There are three modes. In one-sensor mode a single player moves the cursor with sensor A alone. In steering mode a single player uses both sensors. In two-player mode the two sensors compete.

Top module: `tug_ctrl`

## Requirements
- R1: After a synchronous reset, `ready` is 0, `cursor` is 0, and `win_one` and `win_two` are both 0.
- R2: While idle, each sensor's reference is replaced by its reading on every cycle in which that sensor's valid is high. In idle, `cursor` stays 0 and `ready` stays 0 whatever the readings are.
- R3: A `start` pulse while idle takes effect one cycle later: `ready` is 1 and `cursor` is 0. At the same moment both baselines freeze at the references held at the end of the start cycle, which includes any reading that was valid in that cycle. The mode is latched at the same moment.
- R4: Each sensor's drift is its current reading minus its frozen baseline. The readings are treated as unsigned and the drift is signed, one bit wider than a reading.
- R5: In two-player mode (mode 2'b10 or 2'b11), a qualifying cycle moves the cursor down by one when drift A is greater than drift B. Otherwise it moves the cursor up by one, and this includes a tie.
- R6: In steering mode (mode 2'b01), a qualifying cycle moves the cursor down when drift A is greater than drift B, up when drift A is less than drift B, and leaves it unchanged when they are equal.
- R7: In one-sensor mode (mode 2'b00), a qualifying cycle moves the cursor up when drift A is positive, down when it is negative, and leaves it unchanged when it is zero. Sensor B has no effect in this mode.
- R8: In one-sensor mode a cycle qualifies when `temp_a_vld` is high. In the other modes it qualifies only when both valids are high. A cycle that does not qualify leaves `cursor` unchanged. A cursor change appears on the output one clock after the qualifying cycle.
- R9: When the cursor reaches -LIMIT, `win_one` rises; when it reaches +LIMIT, `win_two` rises. In both cases `ready` falls on the same edge. After that, `cursor` and both flags hold until reset, and `start` and the readings have no effect.
- R10: During play, changes on `mode` and pulses on `start` have no effect, so the cursor keeps following the mode latched at start.
- R11: `cursor` never leaves the range -LIMIT to +LIMIT, and at most one win flag is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| temp_a | input | TEMP_W | Sensor A reading, unsigned |
| temp_a_vld | input | 1 | Sensor A reading valid |
| temp_b | input | TEMP_W | Sensor B reading, unsigned |
| temp_b_vld | input | 1 | Sensor B reading valid |
| start | input | 1 | Start request, acted on only while idle |
| mode | input | 2 | 00 one-sensor, 01 steering, 10/11 two-player |
| ready | output | 1 | High while a round is in play |
| cursor | output | CUR_W | Signed cursor position |
| win_one | output | 1 | Cursor reached -LIMIT |
| win_two | output | 1 | Cursor reached +LIMIT |

## Verification
For every mode value, a fresh round is started from fixed baselines. Its first move is then tried with every pair of drifts from -3 to +3 under all four combinations of the two valids. This sweep separates how ties are handled in two-player and steering modes. It also exposes sign errors in the drift and any mode that wrongly ignores a valid or depends on sensor B. Directed rounds cover three further cases:

- a start cycle that also carries valid readings, which must become the baselines;
- mode and start toggling during play;
- runs to each end of the range, followed by stimulus that must not disturb the frozen result.

// File: rtl/tug_pkg.sv
package tug_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PLAY = 2'd1,
    PH_DONE = 2'd2
  } phase_t;

  typedef enum logic [1:0] {
    MD_SOLO  = 2'b00,
    MD_STEER = 2'b01,
    MD_DUEL  = 2'b10,
    MD_DUEL2 = 2'b11
  } mode_t;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_t;

endpackage

// File: rtl/tug_baseline.sv
module tug_baseline #(
  parameter int TEMP_W = 8,
  localparam int DW = TEMP_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 track,
  input  logic [TEMP_W-1:0]    sample,
  input  logic                 sample_vld,
  output logic signed [DW-1:0] drift
);

  logic [TEMP_W-1:0] base_q;

  // R4: signed change of a reading against its frozen reference
  function automatic logic signed [DW-1:0] drift_of(
    input logic [TEMP_W-1:0] now,
    input logic [TEMP_W-1:0] ref_v
  );
    drift_of = $signed({1'b0, now}) - $signed({1'b0, ref_v});
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
    end else if (track && sample_vld) begin
      base_q <= sample;
    end
  end

  assign drift = drift_of(sample, base_q);

  // R3
  base_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !track |=> $stable(base_q));

  // R2
  base_track_chk: assert property (@(posedge clk) disable iff (rst)
    (track && sample_vld) |=> (base_q == $past(sample)));

endmodule

// File: rtl/tug_step_rule.sv
module tug_step_rule
  import tug_pkg::*;
#(
  parameter int DW = 9
) (
  input  logic [1:0]           mode,
  input  logic signed [DW-1:0] drift_a,
  input  logic signed [DW-1:0] drift_b,
  output step_t                step
);

  function automatic step_t pick_step(
    input logic [1:0]           md,
    input logic signed [DW-1:0] da,
    input logic signed [DW-1:0] db
  );
    step_t s;
    s = STEP_HOLD;
    unique case (mode_t'(md))
      MD_SOLO: begin
        if (da[DW-1])              s = STEP_DOWN;
        else if (da != {DW{1'b0}}) s = STEP_UP;
        else                       s = STEP_HOLD;
      end
      MD_STEER: begin
        if (da > db)      s = STEP_DOWN;
        else if (da < db) s = STEP_UP;
        else              s = STEP_HOLD;
      end
      MD_DUEL, MD_DUEL2: begin
        s = (da > db) ? STEP_DOWN : STEP_UP;
      end
      default: s = STEP_HOLD;
    endcase
    return s;
  endfunction

  assign step = pick_step(mode, drift_a, drift_b);

endmodule

// File: rtl/tug_cursor.sv
module tug_cursor
  import tug_pkg::*;
#(
  parameter int LIMIT = 16,
  localparam int CUR_W = $clog2(LIMIT + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    center,
  input  logic                    apply,
  input  step_t                   step,
  output logic signed [CUR_W-1:0] cursor,
  output logic                    hit_lo,
  output logic                    hit_hi,
  output logic                    win_lo,
  output logic                    win_hi
);

  localparam logic signed [CUR_W-1:0] TOP = CUR_W'(LIMIT);
  localparam logic signed [CUR_W-1:0] BOT = -TOP;
  localparam logic signed [CUR_W-1:0] ONE = CUR_W'(1);

  logic signed [CUR_W-1:0] cur_q, cur_nxt;

  function automatic logic signed [CUR_W-1:0] move(
    input logic signed [CUR_W-1:0] c,
    input step_t                   s
  );
    logic signed [CUR_W-1:0] r;
    r = c;
    unique case (s)
      STEP_UP:   if (c < TOP) r = c + ONE;
      STEP_DOWN: if (c > BOT) r = c - ONE;
      default:   r = c;
    endcase
    return r;
  endfunction

  assign cur_nxt = move(cur_q, step);
  assign hit_lo  = apply && (cur_nxt == BOT);
  assign hit_hi  = apply && (cur_nxt == TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      win_lo <= 1'b0;
      win_hi <= 1'b0;
    end else begin
      if (center)     cur_q <= '0;
      else if (apply) cur_q <= cur_nxt;
      if (hit_lo) win_lo <= 1'b1;
      if (hit_hi) win_hi <= 1'b1;
    end
  end

  assign cursor = cur_q;

  // R11
  cursor_range_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_q >= BOT) && (cur_q <= TOP));

  // R8
  cursor_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!apply && !center) |=> $stable(cur_q));

  // R8
  cursor_step_chk: assert property (@(posedge clk) disable iff (rst)
    apply |=> (cur_q == $past(cur_q) || cur_q == $past(cur_q) + ONE ||
               cur_q == $past(cur_q) - ONE));

  // R11
  win_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({win_lo, win_hi}));

  // R9
  win_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (win_lo || win_hi) |=> ($stable(win_lo) && $stable(win_hi)));

endmodule

// File: rtl/tug_ctrl.sv
module tug_ctrl
  import tug_pkg::*;
#(
  parameter int TEMP_W = 8,
  parameter int LIMIT  = 16,
  localparam int DW    = TEMP_W + 1,
  localparam int CUR_W = $clog2(LIMIT + 1) + 1,
  localparam int NSENS = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [TEMP_W-1:0]       temp_a,
  input  logic                    temp_a_vld,
  input  logic [TEMP_W-1:0]       temp_b,
  input  logic                    temp_b_vld,
  input  logic                    start,
  input  logic [1:0]              mode,
  output logic                    ready,
  output logic signed [CUR_W-1:0] cursor,
  output logic                    win_one,
  output logic                    win_two
);

  phase_t     phase_q, phase_nxt;
  logic [1:0] mode_q;
  logic       in_idle, in_play, go, vld_ok, apply;
  logic       hit_lo, hit_hi;
  step_t      step;

  logic [TEMP_W-1:0]       rd  [NSENS];
  logic                    rv  [NSENS];
  logic signed [DW-1:0]    dft [NSENS];

  assign rd[0] = temp_a;
  assign rd[1] = temp_b;
  assign rv[0] = temp_a_vld;
  assign rv[1] = temp_b_vld;

  assign in_idle = (phase_q == PH_IDLE);
  assign in_play = (phase_q == PH_PLAY);
  assign go      = in_idle && start;

  for (genvar g = 0; g < NSENS; g++) begin : g_ref
    tug_baseline #(.TEMP_W(TEMP_W)) u_ref (
      .clk        (clk),
      .rst        (rst),
      .track      (in_idle),
      .sample     (rd[g]),
      .sample_vld (rv[g]),
      .drift      (dft[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)     mode_q <= MD_SOLO;
    else if (go) mode_q <= mode;
  end

  assign vld_ok = (mode_t'(mode_q) == MD_SOLO) ? temp_a_vld
                                               : (temp_a_vld && temp_b_vld);
  assign apply  = in_play && vld_ok;

  tug_step_rule #(.DW(DW)) u_rule (
    .mode    (mode_q),
    .drift_a (dft[0]),
    .drift_b (dft[1]),
    .step    (step)
  );

  tug_cursor #(.LIMIT(LIMIT)) u_cur (
    .clk    (clk),
    .rst    (rst),
    .center (go),
    .apply  (apply),
    .step   (step),
    .cursor (cursor),
    .hit_lo (hit_lo),
    .hit_hi (hit_hi),
    .win_lo (win_one),
    .win_hi (win_two)
  );

  always_comb begin
    phase_nxt = phase_q;
    unique case (phase_q)
      PH_IDLE: if (start) phase_nxt = PH_PLAY;
      PH_PLAY: if (hit_lo || hit_hi) phase_nxt = PH_DONE;
      PH_DONE: phase_nxt = PH_DONE;
      default: phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_IDLE;
    else     phase_q <= phase_nxt;
  end

  assign ready = in_play;

  // R3
  start_center_chk: assert property (@(posedge clk) disable iff (rst)
    go |=> (ready && cursor == '0));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    in_idle |-> (!ready && cursor == '0 && !win_one && !win_two));

  // R9
  ready_win_chk: assert property (@(posedge clk) disable iff (rst)
    !(ready && (win_one || win_two)));

  // R9
  done_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_DONE) |=> ((phase_q == PH_DONE) && $stable(cursor)));

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_idle |=> $stable(mode_q));

  // R5
  duel_moves_chk: assert property (@(posedge clk) disable iff (rst)
    (apply && mode_q[1]) |=> (cursor != $past(cursor)));

endmodule

// File: tb/tug_ctrl_tb.sv
module tug_ctrl_tb;

  localparam int TW  = 8;
  localparam int LIM = 16;
  localparam int CW  = $clog2(LIM + 1) + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [TW-1:0] temp_a = '0, temp_b = '0;
  logic          temp_a_vld = 1'b0, temp_b_vld = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic          ready;
  logic signed [CW-1:0] cursor;
  logic          win_one, win_two;

  int checks = 0;
  int errors = 0;

  // reference model state
  int m_phase, m_ba, m_bb, m_cur, m_mode;
  bit m_w1, m_w2;

  tug_ctrl #(.TEMP_W(TW), .LIMIT(LIM)) u_dut (
    .clk(clk), .rst(rst),
    .temp_a(temp_a), .temp_a_vld(temp_a_vld),
    .temp_b(temp_b), .temp_b_vld(temp_b_vld),
    .start(start), .mode(mode),
    .ready(ready), .cursor(cursor),
    .win_one(win_one), .win_two(win_two)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, "ready",   int'(ready),   (m_phase == 1) ? 1 : 0);
    chk(tag, "cursor",  int'(cursor),  m_cur);
    chk(tag, "win_one", int'(win_one), int'(m_w1));
    chk(tag, "win_two", int'(win_two), int'(m_w2));
  endtask

  function automatic int want_step(input int md, input int da, input int db);
    if (md == 0)      return (da > 0) ? 1 : ((da < 0) ? -1 : 0);
    else if (md == 1) return (db > da) ? 1 : ((db < da) ? -1 : 0);
    else              return (da <= db) ? 1 : -1;
  endfunction

  task automatic cyc(input int a, input bit av, input int b, input bit bv,
                     input bit st, input int md, input string tag);
    bit use_it;
    @(negedge clk);
    rst = 1'b0;
    temp_a = TW'(a); temp_a_vld = av;
    temp_b = TW'(b); temp_b_vld = bv;
    start = st; mode = 2'(md);
    @(posedge clk);
    case (m_phase)
      0: begin
        if (av) m_ba = a;
        if (bv) m_bb = b;
        if (st) begin m_phase = 1; m_mode = md; m_cur = 0; end
      end
      1: begin
        use_it = (m_mode == 0) ? av : (av && bv);
        if (use_it) begin
          m_cur += want_step(m_mode, a - m_ba, b - m_bb);
          if (m_cur <= -LIM) begin m_cur = -LIM; m_w1 = 1; m_phase = 2; end
          if (m_cur >= LIM)  begin m_cur = LIM;  m_w2 = 1; m_phase = 2; end
        end
      end
      default: ;
    endcase
    #2;
    chk_all(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; start = 1'b0; temp_a_vld = 1'b0; temp_b_vld = 1'b0;
    @(posedge clk);
    m_phase = 0; m_ba = 0; m_bb = 0; m_cur = 0; m_mode = 0; m_w1 = 0; m_w2 = 0;
    #2;
    chk_all("R1");
  endtask

  initial begin : watchdog
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    string tg;
    // R1 reset state
    do_reset();

    // R2 idle tracking, R3 baseline includes start cycle, R4 drift sign
    cyc(30, 1, 40, 0, 0, 0, "R2");
    cyc(31, 0, 45, 1, 0, 0, "R2");
    cyc(200, 1, 9, 1, 0, 3, "R2");
    cyc(33, 1, 47, 0, 1, 0, "R3");
    cyc(33, 1, 0, 0, 0, 0, "R4");
    cyc(34, 1, 0, 0, 0, 0, "R4");
    cyc(20, 1, 0, 0, 0, 0, "R4");
    do_reset();
    cyc(10, 1, 200, 1, 0, 1, "R2");
    cyc(0, 0, 0, 0, 1, 1, "R3");
    cyc(12, 1, 201, 1, 0, 1, "R4");
    cyc(9, 1, 199, 1, 0, 1, "R4");

    // sweep of first move: every mode, drift pair and valid pair
    for (int md = 0; md < 4; md++) begin
      for (int da = -3; da <= 3; da++) begin
        for (int db = -3; db <= 3; db++) begin
          for (int vv = 0; vv < 4; vv++) begin
            do_reset();
            cyc(100, 1, 60, 1, 0, md, "R2");
            cyc(0, 0, 0, 0, 1, md, "R3");
            if (vv != 3 && !(md == 0 && vv[0])) tg = "R8";
            else if (md == 0) tg = "R7";
            else if (md == 1) tg = "R6";
            else              tg = "R5";
            cyc(100 + da, vv[0], 60 + db, vv[1], 0, md, tg);
          end
        end
      end
    end

    // R10: mode and start changes during play are ignored
    do_reset();
    cyc(50, 1, 50, 1, 0, 0, "R2");
    cyc(50, 0, 50, 0, 1, 0, "R3");
    for (int k = 0; k < 4; k++) cyc(49, 1, 90, 1, 1, 2, "R10");
    cyc(52, 1, 0, 0, 1, 1, "R10");

    // R9: two-player run to the low end, then frozen
    do_reset();
    cyc(80, 1, 80, 1, 0, 2, "R2");
    cyc(0, 0, 0, 0, 1, 2, "R3");
    for (int k = 0; k < LIM; k++) cyc(85, 1, 80, 1, 0, 2, "R9");
    for (int k = 0; k < 4; k++) cyc(70, 1, 95, 1, 1, 0, "R9");

    // R9/R11: one-sensor run to the high end, overshoot attempts
    do_reset();
    cyc(5, 1, 0, 0, 0, 0, "R2");
    cyc(5, 0, 0, 0, 1, 0, "R3");
    for (int k = 0; k < LIM + 4; k++) cyc(9, 1, 0, 0, 0, 0, "R11");

    // R6: steering run with alternating moves stays in range
    do_reset();
    cyc(120, 1, 120, 1, 0, 1, "R2");
    cyc(0, 0, 0, 0, 1, 1, "R3");
    for (int k = 0; k < 40; k++)
      cyc(120 + (k % 5) - 2, 1, 120 + (k % 3) - 1, (k % 7) != 0, 0, 1, "R6");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule